// File: doc/BRIEF.md
# Two-Core Mailbox Queue Pair

This block lets two processor cores that share one clock pass 32-bit words to each other. It holds two independent first-in first-out queues, each eight words deep. One queue carries words from core 0 to core 1, and the other carries words from core 1 to core 0. The queues are cross-coupled. Each core can only push into its outbound queue and can only pop from its inbound queue.

Each core reaches the block through its own small register port. The port has a select strobe, a write strobe, a two-bit address, write data and combinational read data. The port decodes three registers:

- Address 0 is status.
- Address 1 is send; a write pushes the word.
- Address 2 is receive; a read returns the oldest word and pops it on the same clock edge.

Address 3 reads as zero, and writes to it are ignored. A push into a full queue is dropped and sets a sticky overflow flag. A pop from an empty queue returns zero, leaves the queue as it was and sets a sticky underflow flag. Each core has one level interrupt. It is high while the inbound queue holds data or either sticky flag is set. Software clears a sticky flag by writing 1 to its bit.

Top module: `mbox_pair`

## Requirements
- R1: After reset, the status of each core reads 0x2, and both interrupts are low. In status, bit 0 = inbound not empty, bit 1 = outbound not full, bit 2 = overflow flag, bit 3 = underflow flag, and bits 31:4 read zero.
- R2: Words that core 0 writes to address 1 are read by core 1 at address 2 in the same order.
- R3: Words that core 1 writes to address 1 are read by core 0 at address 2 in the same order, independently of the other queue.
- R4: Status bit 0 is 1 exactly when the core's inbound queue holds at least one word. Status bit 1 is 0 exactly when the core's outbound queue holds eight words.
- R5: A write to address 1 while the outbound queue is full is discarded, and it sets status bit 2 on the next cycle. The eight stored words are read out unchanged.
- R6: A read of address 2 while the inbound queue is empty returns zero and sets status bit 3. The queue stays empty.
- R7: Writing a 1 to status bit 2 or bit 3 clears that flag, and writing 0 leaves it set. Bits 0 and 1 ignore status writes. If a flag is set and cleared in the same cycle, it ends up set.
- R8: Each core's interrupt equals the OR of its status bits 0, 2 and 3.
- R9: A push and a pop on the same queue in one cycle both take effect, and the occupancy is unchanged.
- R10: A read of address 2 on a non-empty queue returns the oldest word in that same access. The next read returns the following word.
- R11: Reads of address 3 return zero, and writes to address 3 change no status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both cores |
| rst_n | input | 1 | Synchronous active-low reset |
| c0_sel | input | 1 | Core 0 register access strobe |
| c0_we | input | 1 | Core 0 write (1) or read (0) |
| c0_addr | input | 2 | Core 0 register address |
| c0_wdata | input | 32 | Core 0 write data |
| c0_rdata | output | 32 | Core 0 read data, combinational |
| c0_irq | output | 1 | Core 0 level interrupt |
| c1_sel | input | 1 | Core 1 register access strobe |
| c1_we | input | 1 | Core 1 write (1) or read (0) |
| c1_addr | input | 2 | Core 1 register address |
| c1_wdata | input | 32 | Core 1 write data |
| c1_rdata | output | 32 | Core 1 read data, combinational |
| c1_irq | output | 1 | Core 1 level interrupt |

## Verification
A wrong read or write pointer shows up at the receive register. The word read back differs from the next word in the scoreboard at the first pop after the fault. If the fault sits in an unread slot, it shows one lap of the queue later. A wrong occupancy count shows up in status bits 0 and 1. It also shows up as a missing or spurious overflow or underflow flag on the cycle after the access, and through the interrupt in the same cycle as the flag. A sticky flag that clears or sets by itself shows in the next status read. So the bench reads status after every boundary access.

// File: rtl/mbox_pkg.sv
// Package: shared constants for the two-core mailbox.
// Assumes: both cores use the same register map and word width.
package mbox_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned QDEPTH = 8;
    localparam int unsigned ADDR_W = 2;
    localparam int unsigned NCORE  = 2;
    localparam int unsigned ST_W   = 4;

    localparam logic [ADDR_W-1:0] A_STAT = 2'd0;
    localparam logic [ADDR_W-1:0] A_SEND = 2'd1;
    localparam logic [ADDR_W-1:0] A_RECV = 2'd2;

    // Status bit positions (software visible)
    localparam int unsigned B_AVAIL = 0;
    localparam int unsigned B_ROOM  = 1;
    localparam int unsigned B_OVF   = 2;
    localparam int unsigned B_UNF   = 3;
endpackage

// File: rtl/mbox_fifo.sv
// Module: mbox_fifo
// Circular-buffer queue with an occupancy counter.
// Assumes: the caller only asserts push when not full and pop when not
// empty; the queue gates both again so that it never corrupts itself.
// Push and pop in one cycle are both honoured.
module mbox_fifo #(
    parameter int unsigned W = 32,
    parameter int unsigned D = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int unsigned AW = (D > 1) ? $clog2(D) : 1;
    localparam int unsigned CW = $clog2(D + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(D);
    localparam logic [AW-1:0] PTR_LAST = AW'(D - 1);

    logic [W-1:0]  mem [D];
    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CNT_MAX);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rptr];

    // Storage write: the slot at the write pointer takes the pushed word
    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= push_data;
    end

    // Write pointer advance with wrap at depth
    always_ff @(posedge clk) begin
        if (!rst_n)       wptr <= '0;
        else if (do_push) wptr <= (wptr == PTR_LAST) ? '0 : wptr + 1'b1;
    end

    // Read pointer advance with wrap at depth
    always_ff @(posedge clk) begin
        if (!rst_n)      rptr <= '0;
        else if (do_pop) rptr <= (rptr == PTR_LAST) ? '0 : rptr + 1'b1;
    end

    // Occupancy count tracks both push and pop in one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else begin
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/mbox_port.sv
// Module: mbox_port
// Register port of one core: decodes the access, drives its outbound
// push and inbound pop, holds the sticky error flags, builds the
// status word and the level interrupt.
// Assumes: one access per cycle; read data is combinational and valid
// while sel is high with we low.
module mbox_port
    import mbox_pkg::*;
#(
    parameter int unsigned W = WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    output logic [W-1:0]      rdata,
    output logic              irq,
    output logic [ST_W-1:0]   status,
    input  logic [W-1:0]      rx_head,
    input  logic              rx_empty,
    input  logic              tx_full,
    output logic              tx_push,
    output logic [W-1:0]      tx_data,
    output logic              rx_pop
);
    logic wr_send, rd_recv, wr_stat;
    logic ovf_q, unf_q;
    logic ovf_set, unf_set, ovf_clr, unf_clr;

    // Access decode
    always_comb begin
        wr_send = sel && we  && (addr == A_SEND);
        rd_recv = sel && !we && (addr == A_RECV);
        wr_stat = sel && we  && (addr == A_STAT);
    end

    // Queue control: only legal pushes and pops leave the port
    always_comb begin
        tx_push = wr_send && !tx_full;
        tx_data = wdata;
        rx_pop  = rd_recv && !rx_empty;
    end

    // Flag events: misuse sets, a write of one clears
    always_comb begin
        ovf_set = wr_send && tx_full;
        unf_set = rd_recv && rx_empty;
        ovf_clr = wr_stat && wdata[B_OVF];
        unf_clr = wr_stat && wdata[B_UNF];
    end

    // Overflow flag, set has priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n)       ovf_q <= 1'b0;
        else if (ovf_set) ovf_q <= 1'b1;
        else if (ovf_clr) ovf_q <= 1'b0;
    end

    // Underflow flag, set has priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n)       unf_q <= 1'b0;
        else if (unf_set) unf_q <= 1'b1;
        else if (unf_clr) unf_q <= 1'b0;
    end

    // Status word assembly
    always_comb begin
        status          = '0;
        status[B_AVAIL] = !rx_empty;
        status[B_ROOM]  = !tx_full;
        status[B_OVF]   = ovf_q;
        status[B_UNF]   = unf_q;
    end

    // Level interrupt from data-available and both error flags
    assign irq = !rx_empty || ovf_q || unf_q;

    // Read data mux, zero when nothing readable is addressed
    always_comb begin
        rdata = '0;
        if (sel && !we) begin
            case (addr)
                A_STAT:  rdata = W'(status);
                A_RECV:  rdata = rx_empty ? '0 : rx_head;
                default: rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/mbox_pair.sv
// Module: mbox_pair
// Two-core mailbox: two queues, cross-coupled so that core c pushes
// queue c and pops queue 1-c, and one register port per core.
// Assumes: both cores run on clk; reset is synchronous, active low.
module mbox_pair
    import mbox_pkg::*;
#(
    parameter int unsigned W = WORD_W,
    parameter int unsigned D = QDEPTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              c0_sel,
    input  logic              c0_we,
    input  logic [ADDR_W-1:0] c0_addr,
    input  logic [W-1:0]      c0_wdata,
    output logic [W-1:0]      c0_rdata,
    output logic              c0_irq,
    input  logic              c1_sel,
    input  logic              c1_we,
    input  logic [ADDR_W-1:0] c1_addr,
    input  logic [W-1:0]      c1_wdata,
    output logic [W-1:0]      c1_rdata,
    output logic              c1_irq
);
    logic              sel   [NCORE];
    logic              we    [NCORE];
    logic [ADDR_W-1:0] addr  [NCORE];
    logic [W-1:0]      wdata [NCORE];
    logic [W-1:0]      rdata [NCORE];
    logic              irq   [NCORE];
    logic [ST_W-1:0]   stat  [NCORE];
    logic              push  [NCORE];
    logic [W-1:0]      pdata [NCORE];
    logic              pop   [NCORE];
    logic [W-1:0]      head  [NCORE];
    logic              empty [NCORE];
    logic              full  [NCORE];
    logic [ST_W-1:0]   c0_st, c1_st;

    // Pin to array mapping
    always_comb begin
        sel[0] = c0_sel;  we[0] = c0_we;  addr[0] = c0_addr;  wdata[0] = c0_wdata;
        sel[1] = c1_sel;  we[1] = c1_we;  addr[1] = c1_addr;  wdata[1] = c1_wdata;
        c0_rdata = rdata[0];  c0_irq = irq[0];  c0_st = stat[0];
        c1_rdata = rdata[1];  c1_irq = irq[1];  c1_st = stat[1];
    end

    // Queue c carries words from core c to core 1-c
    for (genvar c = 0; c < NCORE; c++) begin : g_core
        localparam int unsigned PEER = NCORE - 1 - c;

        mbox_fifo #(.W(W), .D(D)) u_q (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (push[c]),
            .push_data (pdata[c]),
            .pop       (pop[PEER]),
            .head      (head[c]),
            .empty     (empty[c]),
            .full      (full[c])
        );

        mbox_port #(.W(W)) u_port (
            .clk      (clk),
            .rst_n    (rst_n),
            .sel      (sel[c]),
            .we       (we[c]),
            .addr     (addr[c]),
            .wdata    (wdata[c]),
            .rdata    (rdata[c]),
            .irq      (irq[c]),
            .status   (stat[c]),
            .rx_head  (head[PEER]),
            .rx_empty (empty[PEER]),
            .tx_full  (full[c]),
            .tx_push  (push[c]),
            .tx_data  (pdata[c]),
            .rx_pop   (pop[c])
        );
    end
endmodule

// File: rtl/mbox_pair_chk.sv
// Module: mbox_pair_chk
// Temporal checks on the mailbox, bound into every mbox_pair instance.
// Assumes: status vectors of both cores are visible at the top.
module mbox_pair_chk
    import mbox_pkg::*;
#(
    parameter int unsigned W = WORD_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              c0_sel,
    input logic              c0_we,
    input logic [ADDR_W-1:0] c0_addr,
    input logic [W-1:0]      c0_wdata,
    input logic              c0_irq,
    input logic [ST_W-1:0]   c0_st,
    input logic              c1_sel,
    input logic              c1_we,
    input logic [ADDR_W-1:0] c1_addr,
    input logic              c1_irq,
    input logic [ST_W-1:0]   c1_st
);
    // R5
    ovf_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c0_sel && c0_we && c0_addr == A_SEND && !c0_st[B_ROOM]) |=> c0_st[B_OVF]);

    // R6
    unf_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c1_sel && !c1_we && c1_addr == A_RECV && !c1_st[B_AVAIL]) |=> c1_st[B_UNF]);

    // R7
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c0_st[B_OVF] && !(c0_sel && c0_we && c0_addr == A_STAT && c0_wdata[B_OVF]))
        |=> c0_st[B_OVF]);

    // R2
    cross_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c0_sel && c0_we && c0_addr == A_SEND && c0_st[B_ROOM]
         && !(c1_sel && !c1_we && c1_addr == A_RECV)) |=> c1_st[B_AVAIL]);

    // R8
    irq0_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c0_st[B_AVAIL] || c0_st[B_OVF] || c0_st[B_UNF]) |-> c0_irq);

    // R8
    irq1_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(c1_st[B_AVAIL] || c1_st[B_OVF] || c1_st[B_UNF]) |-> !c1_irq);
endmodule

bind mbox_pair mbox_pair_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .c0_sel   (c0_sel),
    .c0_we    (c0_we),
    .c0_addr  (c0_addr),
    .c0_wdata (c0_wdata),
    .c0_irq   (c0_irq),
    .c0_st    (c0_st),
    .c1_sel   (c1_sel),
    .c1_we    (c1_we),
    .c1_addr  (c1_addr),
    .c1_irq   (c1_irq),
    .c1_st    (c1_st)
);

// File: tb/sim_mbox_pair.sv
// Bench: scoreboard of one queue per direction; the driver pushes
// expected words, the monitor pops and compares on every receive read.
module sim_mbox_pair;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        c0_sel = 0, c0_we = 0, c1_sel = 0, c1_we = 0;
    logic [1:0]  c0_addr = 0, c1_addr = 0;
    logic [31:0] c0_wdata = 0, c1_wdata = 0;
    logic [31:0] c0_rdata, c1_rdata;
    logic        c0_irq, c1_irq;

    int total = 0;
    int bad = 0;
    logic [31:0] sb0 [$];   // core0 -> core1
    logic [31:0] sb1 [$];   // core1 -> core0

    always #10 clk = ~clk;  // 50 MHz

    mbox_pair u0 (
        .clk(clk), .rst_n(rst_n),
        .c0_sel(c0_sel), .c0_we(c0_we), .c0_addr(c0_addr), .c0_wdata(c0_wdata),
        .c0_rdata(c0_rdata), .c0_irq(c0_irq),
        .c1_sel(c1_sel), .c1_we(c1_we), .c1_addr(c1_addr), .c1_wdata(c1_wdata),
        .c1_rdata(c1_rdata), .c1_irq(c1_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One access by one core; read data sampled before the clock edge
    task automatic acc(input int core, input logic we, input logic [1:0] a,
                       input logic [31:0] d, output logic [31:0] rd);
        @(negedge clk);
        if (core == 0) begin c0_sel = 1; c0_we = we; c0_addr = a; c0_wdata = d; end
        else           begin c1_sel = 1; c1_we = we; c1_addr = a; c1_wdata = d; end
        #1 rd = (core == 0) ? c0_rdata : c1_rdata;
        @(posedge clk);
        #1 c0_sel = 0; c1_sel = 0;
    endtask

    function automatic int qsize(input int dir);
        return (dir == 0) ? sb0.size() : sb1.size();
    endfunction

    // Driver: push a word, scoreboard it when it fits
    task automatic send(input int core, input logic [31:0] d);
        logic [31:0] rd;
        if (qsize(core) < 8) begin
            if (core == 0) sb0.push_back(d); else sb1.push_back(d);
        end
        acc(core, 1'b1, 2'd1, d, rd);
    endtask

    // Monitor: read receive register and compare with scoreboard front
    task automatic recv(input int core, input string req);
        logic [31:0] rd, exp;
        acc(core, 1'b0, 2'd2, 32'h0, rd);
        if (core == 0) exp = (sb1.size() > 0) ? sb1.pop_front() : 32'h0;
        else           exp = (sb0.size() > 0) ? sb0.pop_front() : 32'h0;
        chk(req, rd, exp);
    endtask

    task automatic stat(input int core, input logic [31:0] exp, input string req);
        logic [31:0] rd;
        acc(core, 1'b0, 2'd0, 32'h0, rd);
        chk(req, rd, exp);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        stat(0, 32'h2, "R1 core0 status");
        stat(1, 32'h2, "R1 core1 status");
        chk("R1 irq", {c0_irq, c1_irq}, 32'h0);

        // R2 / R4 / R8 / R10 core0 -> core1
        send(0, 32'hA0000001); send(0, 32'hA0000002); send(0, 32'hA0000003);
        stat(1, 32'h3, "R4 core1 avail");
        #1 chk("R8 irq1 on data", c1_irq, 1);
        recv(1, "R10 oldest first"); recv(1, "R2 order"); recv(1, "R2 order");
        stat(1, 32'h2, "R4 core1 drained");
        chk("R8 irq1 low", c1_irq, 0);

        // R3 core1 -> core0, independent
        send(1, 32'hB0000011); send(1, 32'hB0000022);
        stat(1, 32'h2, "R3 core1 sees no inbound");
        recv(0, "R3 order"); recv(0, "R3 order");

        // R4 / R5 fill and overflow
        for (int i = 0; i < 8; i++) send(0, 32'hC0000000 + i);
        stat(0, 32'h0, "R4 full clears room");
        send(0, 32'hDEADBEEF);
        stat(0, 32'h4, "R5 overflow flag");
        chk("R8 irq0 on overflow", c0_irq, 1);
        for (int i = 0; i < 8; i++) recv(1, "R5 contents intact");

        // R6 underflow
        recv(1, "R6 empty read zero");
        stat(1, 32'hA, "R6 underflow flag");
        stat(1, 32'hA, "R6 still empty");

        // R7 write-one-to-clear
        acc(0, 1'b1, 2'd0, 32'h0, rd);
        stat(0, 32'h6, "R7 zero write keeps flag");
        acc(0, 1'b1, 2'd0, 32'h3, rd);
        stat(0, 32'h6, "R7 ro bits ignore write");
        acc(0, 1'b1, 2'd0, 32'h4, rd);
        stat(0, 32'h2, "R7 clear overflow");
        chk("R8 irq0 low", c0_irq, 0);
        acc(1, 1'b1, 2'd0, 32'h8, rd);
        stat(1, 32'h2, "R7 clear underflow");

        // R9 push and pop on one queue in the same cycle
        send(0, 32'hE0000001); send(0, 32'hE0000002);
        @(negedge clk);
        c0_sel = 1; c0_we = 1; c0_addr = 2'd1; c0_wdata = 32'hE0000003;
        c1_sel = 1; c1_we = 0; c1_addr = 2'd2;
        #1 chk("R9 same-cycle pop", c1_rdata, sb0.pop_front());
        sb0.push_back(32'hE0000003);
        @(posedge clk);
        #1 c0_sel = 0; c1_sel = 0;
        recv(1, "R9 order"); recv(1, "R9 order");
        stat(1, 32'h2, "R9 count kept");

        // R11 reserved address
        acc(0, 1'b1, 2'd3, 32'hF, rd);
        stat(0, 32'h2, "R11 write ignored");
        acc(0, 1'b0, 2'd3, 32'h0, rd);
        chk("R11 read zero", rd, 32'h0);

        finish_run();
    end
endmodule